// File: doc/BRIEF.md
# Ethernet MAC control and enable register block

This block holds the software-visible control word of an Ethernet MAC, plus a small register that tells the transmit engine a descriptor ring has been refilled. Software uses a plain register bus, with a word address, separate read and write strobes and 32-bit data, to turn the MAC on or off, start a local soft reset, put the bus arbiter into a test mode and toggle a spare output bit. Hardware also changes the register. A soft reset runs a fixed eight-cycle sequence and then clears itself. Error events from the MAC force the enable off. When the enable drops while a frame is being sent, the block asks the transmit side to finish that frame with a corrupted CRC.

Two 4-bit debug tag registers connect the block to a test bus. An input tag is loaded by writes to the control word and is driven onto the test bus whenever another register of the block is written. An output tag captures the test bus tag lines on every read, and a read of the control word returns it.

Top module: `eth_ctrl_regs`

## Requirements
- R1: After the synchronous reset `rst`, the block is in its idle state. `mac_en`, `mac_local_rst`, `tx_crc_corrupt`, `spare_oe` and `tbus_tag_vld` are 0, and the descriptor-active bit, test mode and output tag are 0. The input tag is 4'b1111 and `req_gnt_mask` is all ones.
- R2: The control word at CTRL_ADDR (default 6'h09) has the following layout, with lsb-0 positions. The tag is at [31:28], test mode at [26], spare output enable at [2], MAC enable at [1] and soft reset at [0]. Reserved bits read as 0 and ignore writes. Read data appears on `bus_rdata` after the clock edge that sampled `bus_rd` and holds until the next read.
- R3: A write to the control word with bit [0] = 1 asserts `mac_local_rst` for exactly 8 cycles, starting after the edge that took the write. Bit [0] reads as 1 while the sequence runs and as 0 afterwards.
- R4: The soft-reset write clears the MAC enable, test mode, spare output enable, descriptor-active bit and output tag. It does not raise `tx_crc_corrupt`, even if a frame is in progress.
- R5: While `mac_local_rst` is high, writes to both registers are ignored, with one exception: a control-word write still loads the input tag.
- R6: A pulse on `ev_bus_err`, `ev_txfifo_err` or `ev_rxfifo_err` clears `mac_en` at the next edge. This clear wins over a same-cycle write that sets the enable.
- R7: When the MAC enable falls from 1 to 0 because of a write or an error event while `tx_in_frame` is 1, `tx_crc_corrupt` rises at the same edge. It stays high until `tx_in_frame` is sampled low.
- R8: A write to the control word loads wdata[31:28] into the input tag. A write to any other address drives the input tag on `tbus_tag_out`, with `tbus_tag_vld` = 1 for one cycle.
- R9: Every read, at any address, loads `tbus_tag_in` into the output tag. A control-word read returns the output tag as it was before that read's own capture.
- R10: While test mode is set, `req_gnt_mask` is one-hot on requester SIF_IDX (default 0). Otherwise it is all ones. The mask follows test mode one cycle later.
- R11: Any write to TXACT_ADDR (default 6'h05) sets the descriptor-active bit, read at [24], whatever the data. A `tx_ring_empty` pulse clears it, and a same-cycle write wins.
- R12: `spare_oe` follows the written bit [2] and affects nothing else.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Word address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| ev_bus_err | input | 1 | Bus error event pulse |
| ev_txfifo_err | input | 1 | Transmit FIFO error pulse |
| ev_rxfifo_err | input | 1 | Receive FIFO error pulse |
| tx_ring_empty | input | 1 | No ready transmit descriptors remain |
| tx_in_frame | input | 1 | A frame is being transmitted |
| tbus_tag_in | input | 4 | Test bus tag lines, captured on reads |
| tbus_tag_out | output | 4 | Input tag driven onto the test bus |
| tbus_tag_vld | output | 1 | Test bus tag drive valid |
| mac_en | output | 1 | MAC enable, receive and transmit allowed |
| mac_local_rst | output | 1 | Local reset to the rest of the MAC |
| tx_crc_corrupt | output | 1 | Request to end the current frame with a bad CRC |
| spare_oe | output | 1 | Spare output enable bit |
| req_gnt_mask | output | NREQ | Bus request mask for the arbiter |

## Verification
The enable is driven in several ways: set and cleared by writes, knocked down by each of the three error sources alone, and hit by an error in the same cycle as a setting write. These cases separate the error path from the write path and show which one has priority. The soft reset is tried on an idle block and again with writes arriving during the sequence, which separates the length of the sequence from the write blocking and from the tag-load exception. Tag tests alternate control-word reads with reads at other addresses, showing that the capture happens on every read and that the returned value is the one from before the capture.

// File: rtl/eth_ctrl_pkg.sv
package eth_ctrl_pkg;
  localparam int DATA_W   = 32;
  localparam int TAG_W    = 4;
  localparam int TAG_LSB  = 28;
  localparam int POS_TM   = 26;
  localparam int POS_TXA  = 24;
  localparam int POS_OE   = 2;
  localparam int POS_EN   = 1;
  localparam int POS_RST  = 0;
  localparam logic [TAG_W-1:0] TAG_IN_RESET = '1;
endpackage

// File: rtl/eth_ctrl_rst_seq.sv
module eth_ctrl_rst_seq #(
  parameter int RST_CYCLES = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy
);
  localparam int CNT_W = (RST_CYCLES > 1) ? $clog2(RST_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(RST_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      cnt_q <= '0;
    end else if (!busy) begin
      if (start) begin
        busy  <= 1'b1;
        cnt_q <= '0;
      end
    end else if (cnt_q == LAST) begin
      busy <= 1'b0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/eth_ctrl_tag_unit.sv
module eth_ctrl_tag_unit
  import eth_ctrl_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [TAG_W-1:0] load_val,
  input  logic             drive,
  input  logic             capture,
  input  logic             clear_out,
  input  logic [TAG_W-1:0] tbus_in,
  output logic [TAG_W-1:0] tag_out_q,
  output logic [TAG_W-1:0] tbus_out,
  output logic             tbus_vld
);
  logic [TAG_W-1:0] tag_in_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tag_in_q  <= TAG_IN_RESET;
      tag_out_q <= '0;
      tbus_out  <= '0;
      tbus_vld  <= 1'b0;
    end else begin
      if (load) tag_in_q <= load_val;
      if (clear_out)    tag_out_q <= '0;
      else if (capture) tag_out_q <= tbus_in;
      tbus_vld <= drive;
      if (drive) tbus_out <= tag_in_q;
    end
  end
endmodule

// File: rtl/eth_ctrl_gnt_mask.sv
module eth_ctrl_gnt_mask #(
  parameter int NREQ    = 4,
  parameter int SIF_IDX = 0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            test_mode,
  output logic [NREQ-1:0] mask
);
  for (genvar i = 0; i < NREQ; i++) begin : g_req
    localparam bit IS_SIF = (i == SIF_IDX);
    always_ff @(posedge clk) begin
      if (rst) mask[i] <= 1'b1;
      else     mask[i] <= IS_SIF ? 1'b1 : !test_mode;
    end
  end
endmodule

// File: rtl/eth_ctrl_regs.sv
module eth_ctrl_regs
  import eth_ctrl_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int CTRL_ADDR  = 9,
  parameter int TXACT_ADDR = 5,
  parameter int RST_CYCLES = 8,
  parameter int NREQ       = 4,
  parameter int SIF_IDX    = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              ev_bus_err,
  input  logic              ev_txfifo_err,
  input  logic              ev_rxfifo_err,
  input  logic              tx_ring_empty,
  input  logic              tx_in_frame,
  input  logic [3:0]        tbus_tag_in,
  output logic [3:0]        tbus_tag_out,
  output logic              tbus_tag_vld,
  output logic              mac_en,
  output logic              mac_local_rst,
  output logic              tx_crc_corrupt,
  output logic              spare_oe,
  output logic [NREQ-1:0]   req_gnt_mask
);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(CTRL_ADDR);
  localparam logic [ADDR_W-1:0] A_TXACT = ADDR_W'(TXACT_ADDR);

  logic             sel_ctrl, sel_txact;
  logic             wr_ctrl, wr_txact, wr_other;
  logic             seq_busy, soft_go, err_any;
  logic             en_nxt;
  logic             tm_q, txact_q;
  logic [TAG_W-1:0] tag_out_q;
  logic [31:0]      rd_mux;

  assign sel_ctrl  = (bus_addr == A_CTRL);
  assign sel_txact = (bus_addr == A_TXACT);
  assign wr_ctrl   = bus_wr && sel_ctrl;
  assign wr_txact  = bus_wr && sel_txact;
  assign wr_other  = bus_wr && !sel_ctrl;
  assign err_any   = ev_bus_err || ev_txfifo_err || ev_rxfifo_err;
  assign soft_go   = wr_ctrl && !seq_busy && bus_wdata[POS_RST];

  // enable next state: hardware error clear has priority over a write
  always_comb begin
    en_nxt = mac_en;
    if (wr_ctrl && !seq_busy) en_nxt = bus_wdata[POS_EN];
    if (err_any)              en_nxt = 1'b0;
  end

  eth_ctrl_rst_seq #(.RST_CYCLES(RST_CYCLES)) u_seq (
    .clk   (clk),
    .rst   (rst),
    .start (soft_go),
    .busy  (seq_busy)
  );
  assign mac_local_rst = seq_busy;

  eth_ctrl_tag_unit u_tag (
    .clk       (clk),
    .rst       (rst),
    .load      (wr_ctrl),
    .load_val  (bus_wdata[TAG_LSB +: TAG_W]),
    .drive     (wr_other),
    .capture   (bus_rd),
    .clear_out (soft_go),
    .tbus_in   (tbus_tag_in),
    .tag_out_q (tag_out_q),
    .tbus_out  (tbus_tag_out),
    .tbus_vld  (tbus_tag_vld)
  );

  eth_ctrl_gnt_mask #(.NREQ(NREQ), .SIF_IDX(SIF_IDX)) u_mask (
    .clk       (clk),
    .rst       (rst),
    .test_mode (tm_q),
    .mask      (req_gnt_mask)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mac_en         <= 1'b0;
      tm_q           <= 1'b0;
      spare_oe       <= 1'b0;
      txact_q        <= 1'b0;
      tx_crc_corrupt <= 1'b0;
    end else if (soft_go) begin
      mac_en         <= 1'b0;
      tm_q           <= 1'b0;
      spare_oe       <= 1'b0;
      txact_q        <= 1'b0;
      tx_crc_corrupt <= 1'b0;
    end else begin
      mac_en <= en_nxt;
      if (wr_ctrl && !seq_busy) begin
        tm_q     <= bus_wdata[POS_TM];
        spare_oe <= bus_wdata[POS_OE];
      end
      if (wr_txact && !seq_busy) txact_q <= 1'b1;
      else if (tx_ring_empty)    txact_q <= 1'b0;
      if (mac_en && !en_nxt && tx_in_frame) tx_crc_corrupt <= 1'b1;
      else if (!tx_in_frame)                tx_crc_corrupt <= 1'b0;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (sel_ctrl) begin
      rd_mux[TAG_LSB +: TAG_W] = tag_out_q;
      rd_mux[POS_TM]  = tm_q;
      rd_mux[POS_OE]  = spare_oe;
      rd_mux[POS_EN]  = mac_en;
      rd_mux[POS_RST] = seq_busy;
    end else if (sel_txact) begin
      rd_mux[POS_TXA] = txact_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/eth_ctrl_regs_chk.sv
module eth_ctrl_regs_chk #(
  parameter int ADDR_W     = 6,
  parameter int TXACT_ADDR = 5,
  parameter int RST_CYCLES = 8,
  parameter int NREQ       = 4,
  parameter int SIF_IDX    = 0
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              ev_bus_err,
  input logic              ev_txfifo_err,
  input logic              ev_rxfifo_err,
  input logic              mac_en,
  input logic              mac_local_rst,
  input logic              tx_crc_corrupt,
  input logic              tm_q,
  input logic              txact_q,
  input logic [NREQ-1:0]   req_gnt_mask
);
  localparam int RUN_W = $clog2(RST_CYCLES + 2);
  logic [RUN_W-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst)                run_q <= '0;
    else if (mac_local_rst) run_q <= run_q + 1'b1;
    else                    run_q <= '0;
  end

  a_r3_rst_not_long: assert property (@(posedge clk) disable iff (rst)
    mac_local_rst |-> (run_q < RUN_W'(RST_CYCLES)));
  a_r3_rst_full_len: assert property (@(posedge clk) disable iff (rst)
    $fell(mac_local_rst) |-> (run_q == RUN_W'(RST_CYCLES)));
  a_r4_rst_en_low: assert property (@(posedge clk) disable iff (rst)
    $rose(mac_local_rst) |-> !mac_en);
  a_r6_err_clears: assert property (@(posedge clk) disable iff (rst)
    (ev_bus_err || ev_txfifo_err || ev_rxfifo_err) |=> !mac_en);
  a_r7_corrupt_off: assert property (@(posedge clk) disable iff (rst)
    tx_crc_corrupt |-> !mac_en);
  a_r11_txact_set: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_W'(TXACT_ADDR) && !mac_local_rst) |=> txact_q);
  a_r10_mask: assert property (@(posedge clk) disable iff (rst)
    tm_q |=> (req_gnt_mask == NREQ'(1) << SIF_IDX));
  a_r10_mask_open: assert property (@(posedge clk) disable iff (rst)
    !tm_q |=> (req_gnt_mask == '1));
endmodule

bind eth_ctrl_regs eth_ctrl_regs_chk #(
  .ADDR_W(ADDR_W), .TXACT_ADDR(TXACT_ADDR), .RST_CYCLES(RST_CYCLES),
  .NREQ(NREQ), .SIF_IDX(SIF_IDX)
) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .ev_bus_err(ev_bus_err), .ev_txfifo_err(ev_txfifo_err),
  .ev_rxfifo_err(ev_rxfifo_err), .mac_en(mac_en),
  .mac_local_rst(mac_local_rst), .tx_crc_corrupt(tx_crc_corrupt),
  .tm_q(tm_q), .txact_q(txact_q), .req_gnt_mask(req_gnt_mask)
);

// File: tb/tb_eth_ctrl_regs.sv
module tb_eth_ctrl_regs;
  localparam int CLK_PERIOD = 10;
  localparam logic [5:0] A_CTRL = 6'h09, A_TXACT = 6'h05, A_OTHER = 6'h01;
  localparam logic [31:0] B_EN = 32'h2, B_RST = 32'h1, B_OE = 32'h4,
                          B_TM = 32'h0400_0000, B_TXA = 32'h0100_0000;

  logic clk = 0, rst = 1;
  logic [5:0] bus_addr = '0;
  logic bus_wr = 0, bus_rd = 0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic ev_bus_err = 0, ev_txfifo_err = 0, ev_rxfifo_err = 0;
  logic tx_ring_empty = 0, tx_in_frame = 0;
  logic [3:0] tbus_tag_in = '0, tbus_tag_out;
  logic tbus_tag_vld, mac_en, mac_local_rst, tx_crc_corrupt, spare_oe;
  logic [3:0] req_gnt_mask;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  eth_ctrl_regs dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ev_bus_err(ev_bus_err),
    .ev_txfifo_err(ev_txfifo_err), .ev_rxfifo_err(ev_rxfifo_err),
    .tx_ring_empty(tx_ring_empty), .tx_in_frame(tx_in_frame),
    .tbus_tag_in(tbus_tag_in), .tbus_tag_out(tbus_tag_out),
    .tbus_tag_vld(tbus_tag_vld), .mac_en(mac_en), .mac_local_rst(mac_local_rst),
    .tx_crc_corrupt(tx_crc_corrupt), .spare_oe(spare_oe),
    .req_gnt_mask(req_gnt_mask)
  );

  task automatic chk(input string what, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", what, got, exp);
    end
  endtask

  task automatic step(); @(negedge clk); endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    @(negedge clk); bus_rd = 0; d = bus_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 mac_en", mac_en, 0);
    chk("R1 local_rst", mac_local_rst, 0);
    chk("R1 corrupt", tx_crc_corrupt, 0);
    chk("R1 spare_oe", spare_oe, 0);
    chk("R1 mask", req_gnt_mask, 4'hF);
    chk("R1 tag vld", tbus_tag_vld, 0);
    rd(A_CTRL, d);  chk("R1 ctrl read", d, 0);
    rd(A_TXACT, d); chk("R1 txact read", d, 0);
    wr(A_OTHER, 0);
    chk("R1 R8 tag_in reset drive", {tbus_tag_vld, tbus_tag_out}, 5'h1F);
    step(); chk("R8 drive one cycle", tbus_tag_vld, 0);
  endtask

  task automatic t_layout();
    logic [31:0] d;
    tbus_tag_in = 4'h0;
    wr(A_CTRL, 32'h0FFF_FFFE);
    chk("R2 en", mac_en, 1); chk("R12 oe", spare_oe, 1);
    rd(A_CTRL, d); chk("R2 readback reserved zero", d, 32'h0400_0006);
    wr(A_OTHER, 0); chk("R8 tag loaded 0", tbus_tag_out, 0);
    wr(A_CTRL, 32'h3000_0004);
    chk("R12 oe only", {mac_en, spare_oe}, 2'b01);
    wr(A_OTHER, 0); chk("R8 tag loaded 3", tbus_tag_out, 4'h3);
    wr(A_CTRL, 0); chk("R12 oe clear", spare_oe, 0);
  endtask

  task automatic t_mask();
    wr(A_CTRL, B_TM); step();
    chk("R10 test mode mask", req_gnt_mask, 4'h1);
    chk("R10 R12 oe untouched", spare_oe, 0);
    wr(A_CTRL, 0); step();
    chk("R10 mask open", req_gnt_mask, 4'hF);
  endtask

  task automatic t_tag_capture();
    logic [31:0] d;
    tbus_tag_in = 4'h5; rd(A_CTRL, d);
    chk("R9 pre-capture value", d[31:28], 4'h0);
    tbus_tag_in = 4'hC; rd(A_OTHER, d);
    chk("R9 other read data", d, 0);
    tbus_tag_in = 4'h2; rd(A_CTRL, d);
    chk("R9 captured on other read", d[31:28], 4'hC);
    rd(A_CTRL, d); chk("R9 captured again", d[31:28], 4'h2);
  endtask

  task automatic t_errors();
    for (int k = 0; k < 3; k++) begin
      wr(A_CTRL, B_EN); chk("R6 enabled", mac_en, 1);
      @(negedge clk);
      ev_bus_err = (k == 0); ev_txfifo_err = (k == 1); ev_rxfifo_err = (k == 2);
      @(negedge clk);
      ev_bus_err = 0; ev_txfifo_err = 0; ev_rxfifo_err = 0;
      chk($sformatf("R6 err source %0d clears", k), mac_en, 0);
    end
    @(negedge clk); bus_wr = 1; bus_addr = A_CTRL; bus_wdata = B_EN; ev_rxfifo_err = 1;
    @(negedge clk); bus_wr = 0; ev_rxfifo_err = 0;
    chk("R6 error beats write", mac_en, 0);
  endtask

  task automatic t_corrupt();
    tx_in_frame = 1;
    wr(A_CTRL, B_EN); chk("R7 no request while on", tx_crc_corrupt, 0);
    wr(A_CTRL, 0);
    chk("R7 request on sw disable", tx_crc_corrupt, 1);
    step(); chk("R7 request held", tx_crc_corrupt, 1);
    tx_in_frame = 0; step();
    chk("R7 request released", tx_crc_corrupt, 0);
    tx_in_frame = 1; wr(A_CTRL, B_EN);
    @(negedge clk); ev_bus_err = 1;
    @(negedge clk); ev_bus_err = 0;
    chk("R7 request on error", tx_crc_corrupt, 1);
    tx_in_frame = 0; step();
    wr(A_CTRL, B_EN); wr(A_CTRL, 0);
    chk("R7 no request when idle", tx_crc_corrupt, 0);
  endtask

  task automatic t_txact();
    logic [31:0] d;
    wr(A_TXACT, 32'h0); rd(A_TXACT, d);
    chk("R11 set by zero write", d, B_TXA);
    @(negedge clk); tx_ring_empty = 1; @(negedge clk); tx_ring_empty = 0;
    rd(A_TXACT, d); chk("R11 cleared by empty", d, 0);
    @(negedge clk); bus_wr = 1; bus_addr = A_TXACT; bus_wdata = '1; tx_ring_empty = 1;
    @(negedge clk); bus_wr = 0; tx_ring_empty = 0;
    rd(A_TXACT, d); chk("R11 write wins", d, B_TXA);
  endtask

  task automatic t_soft_reset();
    logic [31:0] d;
    int n;
    wr(A_CTRL, B_EN | B_OE | B_TM);
    tbus_tag_in = 4'h7; rd(A_CTRL, d);
    tx_in_frame = 1;
    wr(A_CTRL, B_RST | B_EN);
    chk("R4 en cleared", mac_en, 0);
    chk("R4 no corrupt", tx_crc_corrupt, 0);
    chk("R4 oe cleared", spare_oe, 0);
    n = 0;
    while (mac_local_rst && n < 20) begin n++; @(negedge clk); end
    chk("R3 local reset length", n, 8);
    tx_in_frame = 0;
    rd(A_CTRL, d); chk("R3 R4 ctrl after reset", d, 0);
    rd(A_TXACT, d); chk("R4 txact cleared", d, 0);
    chk("R4 mask reopened", req_gnt_mask, 4'hF);
  endtask

  task automatic t_write_during();
    logic [31:0] d;
    wr(A_CTRL, B_RST);
    wr(A_CTRL, 32'h9000_0000 | B_EN | B_OE | B_TM);
    chk("R5 en ignored", mac_en, 0);
    chk("R5 oe ignored", spare_oe, 0);
    wr(A_TXACT, 0);
    tbus_tag_in = 4'h0; rd(A_CTRL, d);
    chk("R3 reset bit reads one", d[0], 1);
    chk("R5 tm ignored", d[26], 0);
    while (mac_local_rst) @(negedge clk);
    rd(A_TXACT, d); chk("R5 txact write ignored", d, 0);
    wr(A_OTHER, 0); chk("R5 tag load still taken", tbus_tag_out, 4'h9);
    wr(A_CTRL, B_EN); chk("R5 writes accepted after", mac_en, 1);
    wr(A_CTRL, 0);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_layout();
    t_mask();
    t_tag_capture();
    t_errors();
    t_corrupt();
    t_txact();
    t_soft_reset();
    t_write_during();
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule